// File: doc/BRIEF.md
# I2C Master Bit and Byte Engine

This block is the serial core of an I2C master. On a command it produces a start condition (or a repeated start when the bus was parked), shifts out a seven-bit target address followed by the direction bit, and then moves a counted number of data bytes. Write bytes come one at a time from a transmit FIFO. Read bytes go one at a time into a receive FIFO. The engine samples the target's acknowledge after the address and after each written byte. On reads it drives the acknowledge itself.

SCL timing comes from two 32-bit phase counts, one for the high phase and one for the low phase. Each count is split across two timing words. A separate count sets how long SCL stays high after SDA falls for a start. A transaction ends in one of two ways. It can issue a stop condition. Or it can leave SCL pulled low with SDA released, so that the next command begins with a repeated start. The bus pins are open-drain enables, where 1 means pull the line low. Clock stretching and arbitration are not handled.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both line enables are 0 and `busy`, `nack`, `done`, `tx_take` and `rx_push` are 0.
- R2: The high-phase count is {word1[31:16], word0[31:16]} and the low-phase count is {word1[15:0], word0[15:0]}. During bit transfer SCL is released for exactly the high count and pulled low for exactly the low count, in clock cycles. A count of 0 acts as 1.
- R3: A start pulls SDA low while SCL is released. SCL then stays released for `tim_start_hold` cycles (0 acts as 1) before the first low phase.
- R4: The first byte on the bus is {cmd_addr, cmd_read}, with cmd_read=1 meaning read, sent MSB first.
- R5: On a write, each data byte is taken from the transmit FIFO by a one-cycle `tx_take` while `tx_valid` is 1, and is sent MSB first. Exactly `cmd_count` bytes are sent when every byte is acknowledged.
- R6: On a read, each received byte (MSB first) is handed over with a one-cycle `rx_push` on `rx_data`. The engine pulls SDA low in the acknowledge slot of every byte except the last counted one, which it leaves released (NACK).
- R7: A released SDA in the acknowledge slot of the address or of a written byte sets `nack`. No further byte is taken, and the transaction ends. `nack` holds until the next accepted command clears it.
- R8: With `cmd_hold_bus`=0 the engine ends with a stop: SDA rises while SCL is released. With `cmd_hold_bus`=1 it ends with SCL pulled low, SDA released and no stop, and the next command begins with a repeated start.
- R9: When a write byte is due and `tx_valid` is 0, SCL stays pulled low and nothing is taken until `tx_valid` returns.
- R10: When a received byte is ready and `rx_ready` is 0, SCL stays pulled low and `rx_push` stays 0 until `rx_ready` returns.
- R11: An accepted `cmd_go` makes `busy` 1 from the next cycle. `done` is high for exactly one cycle, and `busy` is 0 in the cycle after it.
- R12: A command with `cmd_count`=0 sends only the address byte and then ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | Start a transaction (accepted when idle) |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_hold_bus | input | 1 | 1 = end without stop, keep bus for repeated start |
| cmd_addr | input | 7 | Target address |
| cmd_count | input | CNT_W | Number of data bytes |
| tim_word0 | input | TIMER_W | Low halves: high count in upper half, low count in lower half |
| tim_word1 | input | TIMER_W | High halves: high count in upper half, low count in lower half |
| tim_start_hold | input | TIMER_W | Cycles SCL stays high after SDA falls for start |
| tx_valid | input | 1 | Transmit FIFO holds a byte |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_take | output | 1 | Consume the transmit head byte |
| rx_ready | input | 1 | Receive FIFO has room |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| busy | output | 1 | Transaction in progress |
| nack | output | 1 | Target failed to acknowledge |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
A bit-level target model on the bench decodes the bus and answers it. Writes of several bytes show that address and data shift MSB first, and that the transmit FIFO is drained at the right count. Reads with mixed-bit data show that sampling lands in the high phase and that the engine's ACK/NACK pattern marks the last byte. Transactions where the target refuses the address, or refuses a middle data byte, separate early termination from normal completion. Transactions with the transmit FIFO empty or the receive FIFO full show that SCL is held low. An asymmetric timing setting is measured run by run on SCL, which exposes any swap of the word halves or an off-by-one phase.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    localparam int BYTE_W = 8;
    localparam int ACK_SLOT = BYTE_W;

    typedef enum logic [3:0] {
        S_IDLE      = 4'd0,
        S_RS_HIGH   = 4'd1,
        S_START     = 4'd2,
        S_LOW       = 4'd3,
        S_HIGH      = 4'd4,
        S_STOP_LOW  = 4'd5,
        S_STOP_HIGH = 4'd6,
        S_PARK_LOW  = 4'd7,
        S_DONE      = 4'd8
    } eng_state_t;

endpackage

// File: rtl/i2c_eng_timing.sv
// Assembles the split phase counts and clamps every length to at least 1.
module i2c_eng_timing #(
    parameter int TIMER_W = 32
) (
    input  logic [TIMER_W-1:0] tim_word0,
    input  logic [TIMER_W-1:0] tim_word1,
    input  logic [TIMER_W-1:0] tim_start_hold,
    output logic [TIMER_W-1:0] hi_len,
    output logic [TIMER_W-1:0] lo_len,
    output logic [TIMER_W-1:0] sh_len
);
    localparam int HALF = TIMER_W / 2;
    localparam int NLEN = 3;

    logic [TIMER_W-1:0] raw [NLEN];
    logic [TIMER_W-1:0] fixed [NLEN];

    always_comb begin
        raw[0] = {tim_word1[TIMER_W-1:HALF], tim_word0[TIMER_W-1:HALF]};
        raw[1] = {tim_word1[HALF-1:0], tim_word0[HALF-1:0]};
        raw[2] = tim_start_hold;
    end

    for (genvar g = 0; g < NLEN; g++) begin : g_clamp
        assign fixed[g] = (raw[g] == '0) ? TIMER_W'(1) : raw[g];
    end

    assign hi_len = fixed[0];
    assign lo_len = fixed[1];
    assign sh_len = fixed[2];
endmodule

// File: rtl/i2c_eng_timer.sv
// Phase timer: counts cycles inside one bus phase.
module i2c_eng_timer #(
    parameter int TIMER_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [TIMER_W-1:0] len,
    output logic               fresh,
    output logic               last,
    output logic               mid
);
    logic [TIMER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_q + TIMER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign fresh = (cnt_q == '0);
    assign last  = (cnt_q >= len - TIMER_W'(1));
    assign mid   = (cnt_q == (len >> 1));
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_eng_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int TIMER_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_go,
    input  logic               cmd_read,
    input  logic               cmd_hold_bus,
    input  logic [6:0]         cmd_addr,
    input  logic [CNT_W-1:0]   cmd_count,
    input  logic [TIMER_W-1:0] tim_word0,
    input  logic [TIMER_W-1:0] tim_word1,
    input  logic [TIMER_W-1:0] tim_start_hold,
    input  logic               tx_valid,
    input  logic [7:0]         tx_data,
    output logic               tx_take,
    input  logic               rx_ready,
    output logic [7:0]         rx_data,
    output logic               rx_push,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               busy,
    output logic               nack,
    output logic               done
);
    localparam int BIT_W = $clog2(ACK_SLOT + 1);

    typedef struct packed {
        eng_state_t        st;
        logic              scl_low;
        logic              sda_low;
        logic [BYTE_W-1:0] sh;
        logic [BIT_W-1:0]  bit_idx;
        logic              is_addr;
        logic              rd;
        logic              hold;
        logic [CNT_W-1:0]  left;
        logic              nack;
    } eng_regs_t;

    eng_regs_t cur_q, nxt_d;

    logic [TIMER_W-1:0] hi_len, lo_len, sh_len, ph_len;
    logic               t_fresh, t_last, t_mid, t_clr, stall;
    logic               is_ack_slot, wr_load, rd_hand, last_byte, finish;

    i2c_eng_timing #(.TIMER_W(TIMER_W)) u_timing (
        .tim_word0      (tim_word0),
        .tim_word1      (tim_word1),
        .tim_start_hold (tim_start_hold),
        .hi_len         (hi_len),
        .lo_len         (lo_len),
        .sh_len         (sh_len)
    );

    always_comb begin
        case (cur_q.st)
            S_START:                       ph_len = sh_len;
            S_HIGH, S_STOP_HIGH, S_RS_HIGH: ph_len = hi_len;
            default:                       ph_len = lo_len;
        endcase
    end

    i2c_eng_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .en    (!stall),
        .len   (ph_len),
        .fresh (t_fresh),
        .last  (t_last),
        .mid   (t_mid)
    );

    always_comb begin
        is_ack_slot = (cur_q.bit_idx == BIT_W'(ACK_SLOT));
        wr_load     = !cur_q.is_addr && !cur_q.rd && (cur_q.bit_idx == '0);
        rd_hand     = !cur_q.is_addr && cur_q.rd && is_ack_slot;
        last_byte   = cur_q.is_addr ? (cur_q.left == '0) : (cur_q.left == CNT_W'(1));
    end

    always_comb begin
        nxt_d   = cur_q;
        stall   = 1'b0;
        tx_take = 1'b0;
        rx_push = 1'b0;
        finish  = 1'b0;
        case (cur_q.st)
            S_IDLE: begin
                if (cmd_go) begin
                    nxt_d.nack    = 1'b0;
                    nxt_d.rd      = cmd_read;
                    nxt_d.hold    = cmd_hold_bus;
                    nxt_d.left    = cmd_count;
                    nxt_d.is_addr = 1'b1;
                    nxt_d.bit_idx = '0;
                    nxt_d.sh      = {cmd_addr, cmd_read};
                    if (cur_q.scl_low) begin
                        nxt_d.st      = S_RS_HIGH;
                        nxt_d.scl_low = 1'b0;
                    end else begin
                        nxt_d.st      = S_START;
                        nxt_d.sda_low = 1'b1;
                    end
                end
            end
            S_RS_HIGH: begin
                if (t_last) begin
                    nxt_d.st      = S_START;
                    nxt_d.sda_low = 1'b1;
                end
            end
            S_START: begin
                if (t_last) begin
                    nxt_d.st      = S_LOW;
                    nxt_d.scl_low = 1'b1;
                end
            end
            S_LOW: begin
                if (t_fresh) begin
                    if (wr_load) begin
                        if (!tx_valid) begin
                            stall = 1'b1;
                        end else begin
                            nxt_d.sh      = tx_data;
                            nxt_d.sda_low = !tx_data[BYTE_W-1];
                            tx_take       = 1'b1;
                        end
                    end else if (rd_hand) begin
                        if (!rx_ready) begin
                            stall = 1'b1;
                        end else begin
                            rx_push       = 1'b1;
                            nxt_d.sda_low = (cur_q.left > CNT_W'(1));
                        end
                    end else if (is_ack_slot || (cur_q.rd && !cur_q.is_addr)) begin
                        nxt_d.sda_low = 1'b0;
                    end else begin
                        nxt_d.sda_low = !cur_q.sh[BYTE_W-1];
                    end
                end
                if (t_last && !stall) begin
                    nxt_d.st      = S_HIGH;
                    nxt_d.scl_low = 1'b0;
                end
            end
            S_HIGH: begin
                if (t_mid) begin
                    if (!is_ack_slot) begin
                        nxt_d.sh = {cur_q.sh[BYTE_W-2:0], sda_in};
                    end else if ((cur_q.is_addr || !cur_q.rd) && sda_in) begin
                        nxt_d.nack = 1'b1;
                    end
                end
                if (t_last) begin
                    nxt_d.scl_low = 1'b1;
                    if (!is_ack_slot) begin
                        nxt_d.bit_idx = cur_q.bit_idx + BIT_W'(1);
                        nxt_d.st      = S_LOW;
                    end else begin
                        nxt_d.bit_idx = '0;
                        nxt_d.is_addr = 1'b0;
                        if (!cur_q.is_addr) begin
                            nxt_d.left = cur_q.left - CNT_W'(1);
                        end
                        finish = nxt_d.nack || last_byte;
                        if (finish) begin
                            nxt_d.st = cur_q.hold ? S_PARK_LOW : S_STOP_LOW;
                        end else begin
                            nxt_d.st = S_LOW;
                        end
                    end
                end
            end
            S_STOP_LOW: begin
                if (t_fresh) begin
                    nxt_d.sda_low = 1'b1;
                end
                if (t_last) begin
                    nxt_d.st      = S_STOP_HIGH;
                    nxt_d.scl_low = 1'b0;
                end
            end
            S_STOP_HIGH: begin
                if (t_last) begin
                    nxt_d.sda_low = 1'b0;
                    nxt_d.st      = S_DONE;
                end
            end
            S_PARK_LOW: begin
                if (t_fresh) begin
                    nxt_d.sda_low = 1'b0;
                end
                if (t_last) begin
                    nxt_d.st = S_DONE;
                end
            end
            S_DONE: begin
                nxt_d.st = S_IDLE;
            end
            default: begin
                nxt_d.st = S_IDLE;
            end
        endcase
        t_clr = (nxt_d.st != cur_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st      <= S_IDLE;
            cur_q.scl_low <= 1'b0;
            cur_q.sda_low <= 1'b0;
            cur_q.sh      <= '0;
            cur_q.bit_idx <= '0;
            cur_q.is_addr <= 1'b0;
            cur_q.rd      <= 1'b0;
            cur_q.hold    <= 1'b0;
            cur_q.left    <= '0;
            cur_q.nack    <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign scl_oe  = cur_q.scl_low;
    assign sda_oe  = cur_q.sda_low;
    assign busy    = (cur_q.st != S_IDLE);
    assign done    = (cur_q.st == S_DONE);
    assign nack    = cur_q.nack;
    assign rx_data = cur_q.sh;
endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_go,
    input logic tx_valid,
    input logic tx_take,
    input logic rx_ready,
    input logic rx_push,
    input logic sda_oe,
    input logic busy,
    input logic nack,
    input logic done
);
    a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r11_go_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !busy) |=> busy);

    a_r5_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> (tx_valid && busy));

    a_r10_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (rx_ready && busy));

    a_r7_nack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (nack && !cmd_go) |=> nack);

    a_r8_idle_sda_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_oe);
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_go   (cmd_go),
    .tx_valid (tx_valid),
    .tx_take  (tx_take),
    .rx_ready (rx_ready),
    .rx_push  (rx_push),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .nack     (nack),
    .done     (done)
);

// File: tb/i2c_bit_engine_tb.sv
module i2c_bit_engine_tb;
    localparam int CNT_W = 8;
    localparam int TW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cmd_go = 0, cmd_read = 0, cmd_hold_bus = 0;
    logic [6:0]    cmd_addr = '0;
    logic [CNT_W-1:0] cmd_count = '0;
    logic [TW-1:0] tim_word0 = {16'd4, 16'd6};
    logic [TW-1:0] tim_word1 = '0;
    logic [TW-1:0] tim_start_hold = 32'd5;
    logic          tx_valid, tx_take, rx_ready = 1, rx_push;
    logic [7:0]    tx_data, rx_data;
    logic          sda_in, scl_oe, sda_oe, busy, nack, done;
    logic          tgt_low;

    // FIFO models
    logic [7:0] tx_q [64];
    int         tx_fill = 0;
    int         tx_idx = 0;
    logic       tx_en = 1;
    logic [7:0] rx_log [64];
    int         rx_n = 0;

    assign tx_valid = tx_en && (tx_idx < tx_fill);
    assign tx_data  = tx_q[tx_idx[5:0]];
    assign sda_in   = !(sda_oe || tgt_low);

    always @(posedge clk) begin
        if (tx_take) tx_idx <= tx_idx + 1;
        if (rx_push) begin
            rx_log[rx_n[5:0]] <= rx_data;
            rx_n <= rx_n + 1;
        end
    end

    i2c_bit_engine #(.CNT_W(CNT_W), .TIMER_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_read(cmd_read),
        .cmd_hold_bus(cmd_hold_bus), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
        .tim_word0(tim_word0), .tim_word1(tim_word1), .tim_start_hold(tim_start_hold),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_push(rx_push),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .nack(nack), .done(done)
    );

    // Bit-level target model
    int         t_bit = -1, t_byte = 0, t_starts = 0, t_stops = 0;
    int         t_wr_n = 0, t_mack_n = 0, t_rd_len = 0, t_nack_at = -1;
    logic [7:0] t_sh = '0, t_addr_byte = '0;
    logic       t_rd = 0, t_mack = 1;
    logic [7:0] t_wr [64];
    logic [7:0] t_rdat [16];
    logic       t_mack_log [64];
    logic       scl_p = 1, sda_p = 1;

    initial tgt_low = 1'b0;

    always @(negedge clk) begin
        logic scl_l, sda_l;
        scl_l = !scl_oe;
        sda_l = !(sda_oe || tgt_low);
        if (rst_n) begin
            if (scl_p && scl_l && sda_p && !sda_l) begin
                t_starts++; t_bit = -1; t_byte = 0; t_mack = 1; tgt_low = 1'b0;
            end else if (scl_p && scl_l && !sda_p && sda_l) begin
                t_stops++;
            end else if (!scl_p && scl_l) begin
                if (t_bit >= 0 && t_bit < 8) t_sh = {t_sh[6:0], sda_l};
                else if (t_bit == 8 && t_rd && t_byte > 0) begin
                    t_mack = !sda_l;
                    t_mack_log[t_mack_n[5:0]] = !sda_l;
                    t_mack_n++;
                end
            end else if (scl_p && !scl_l) begin
                tgt_low = 1'b0;
                if (t_bit == -1) begin
                    t_bit = 0;
                end else if (t_bit < 7) begin
                    t_bit++;
                    if (t_rd && t_byte > 0 && t_mack && (t_byte - 1) < t_rd_len)
                        tgt_low = !t_rdat[(t_byte - 1) % 16][7 - t_bit];
                end else if (t_bit == 7) begin
                    t_bit = 8;
                    if (t_byte == 0) begin
                        t_addr_byte = t_sh; t_rd = t_sh[0];
                        tgt_low = (t_nack_at != 0);
                    end else if (!t_rd) begin
                        t_wr[t_wr_n[5:0]] = t_sh; t_wr_n++;
                        tgt_low = (t_nack_at != t_byte);
                    end
                end else begin
                    t_bit = 0; t_byte++;
                    if (t_rd && t_mack && (t_byte - 1) < t_rd_len)
                        tgt_low = !t_rdat[(t_byte - 1) % 16][7];
                end
            end
        end
        scl_p = scl_l;
        sda_p = !(sda_oe || tgt_low);
    end

    // SCL phase monitor
    logic mon_en = 0;
    int   exp_hi = 0, exp_lo = 0;
    int   m_run = 0, m_hi_n = 0, m_lo_n = 0, m_hi_bad = 0, m_lo_bad = 0;
    int   m_hold_cnt = 0, m_hold_w = 0;
    logic m_scl_p = 0, m_hi_track = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (scl_oe != m_scl_p) begin
                if (m_scl_p) begin
                    if (m_run != exp_lo) m_lo_bad++;
                    m_lo_n++;
                    m_hi_track = 1;
                end else begin
                    if (m_hi_track) begin
                        if (m_run != exp_hi) m_hi_bad++;
                        m_hi_n++;
                    end else begin
                        m_hold_w = m_hold_cnt;
                    end
                end
                m_run = 1;
            end else begin
                m_run++;
            end
            if (sda_oe && !scl_oe) m_hold_cnt++;
            else if (!sda_oe) m_hold_cnt = 0;
            if (done) m_hi_track = 0;
        end
        m_scl_p = scl_oe;
    end

    // Bookkeeping
    int total = 0, bad = 0, cyc = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic go(input logic [6:0] a, input logic r, input int n, input logic h);
        @(negedge clk);
        cmd_addr = a; cmd_read = r; cmd_count = CNT_W'(n); cmd_hold_bus = h; cmd_go = 1;
        @(negedge clk);
        cmd_go = 0;
    endtask

    task automatic wait_end(output int dones, output int late_busy);
        logic prev_done;
        dones = 0; late_busy = 0; prev_done = 0;
        for (int i = 0; i < 20000; i++) begin
            if (prev_done && busy) late_busy++;
            if (done) dones++;
            if (!busy) break;
            prev_done = done;
            @(negedge clk);
        end
    endtask

    task automatic load_tx(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3, input int n);
        logic [7:0] v [4];
        v[0] = b0; v[1] = b1; v[2] = b2; v[3] = b3;
        for (int k = 0; k < n; k++) tx_q[(tx_fill + k) % 64] = v[k];
        tx_fill = tx_fill + n;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 nack", nack, 0);
        chk("R1 done", done, 0);
        chk("R1 tx_take/rx_push", {tx_take, rx_push}, 0);
    endtask

    task automatic t_write;
        int d, lb, wb, sb, st, tb;
        wb = t_wr_n; sb = t_stops; st = t_starts; tb = tx_idx;
        t_nack_at = -1;
        load_tx(8'hA5, 8'h3C, 8'hF0, 8'h00, 3);
        go(7'h50, 0, 3, 0);
        chk("R11 busy after go", busy, 1);
        wait_end(d, lb);
        chk("R11 one done pulse", d, 1);
        chk("R11 idle after done", lb, 0);
        chk("R4 address byte", t_addr_byte, 8'hA0);
        chk("R5 bytes taken", tx_idx - tb, 3);
        chk("R5 byte0", t_wr[wb % 64], 8'hA5);
        chk("R5 byte1", t_wr[(wb + 1) % 64], 8'h3C);
        chk("R5 byte2", t_wr[(wb + 2) % 64], 8'hF0);
        chk("R8 one start", t_starts - st, 1);
        chk("R8 one stop", t_stops - sb, 1);
        chk("R7 no nack", nack, 0);
    endtask

    task automatic t_read;
        int d, lb, rb, mb, sb;
        rb = rx_n; mb = t_mack_n; sb = t_stops;
        t_rdat[0] = 8'h5A; t_rdat[1] = 8'hC3; t_rdat[2] = 8'h81; t_rd_len = 3;
        go(7'h21, 1, 3, 0);
        wait_end(d, lb);
        chk("R4 read address byte", t_addr_byte, 8'h43);
        chk("R6 push count", rx_n - rb, 3);
        chk("R6 rx0", rx_log[rb % 64], 8'h5A);
        chk("R6 rx1", rx_log[(rb + 1) % 64], 8'hC3);
        chk("R6 rx2", rx_log[(rb + 2) % 64], 8'h81);
        chk("R6 ack byte0", t_mack_log[mb % 64], 1);
        chk("R6 ack byte1", t_mack_log[(mb + 1) % 64], 1);
        chk("R6 nack last", t_mack_log[(mb + 2) % 64], 0);
        chk("R8 stop after read", t_stops - sb, 1);
        chk("R11 read done", d, 1);
    endtask

    task automatic t_addr_nack;
        int d, lb, tb, wb, sb;
        tb = tx_idx; wb = t_wr_n; sb = t_stops;
        t_nack_at = 0;
        load_tx(8'h11, 8'h22, 8'h00, 8'h00, 2);
        go(7'h33, 0, 2, 0);
        wait_end(d, lb);
        chk("R7 addr nack flag", nack, 1);
        chk("R7 nothing taken", tx_idx - tb, 0);
        chk("R7 nothing written", t_wr_n - wb, 0);
        chk("R7 stop issued", t_stops - sb, 1);
        chk("R7 done", d, 1);
        repeat (20) @(negedge clk);
        chk("R7 nack held", nack, 1);
        tx_fill = tx_idx;
    endtask

    task automatic t_data_nack;
        int d, lb, tb, wb;
        tb = tx_idx; wb = t_wr_n;
        t_nack_at = 2;
        load_tx(8'h01, 8'h02, 8'h03, 8'h04, 4);
        go(7'h0F, 0, 4, 0);
        chk("R7 nack cleared by go", nack, 0);
        wait_end(d, lb);
        chk("R7 data nack flag", nack, 1);
        chk("R7 taken up to nack", tx_idx - tb, 2);
        chk("R7 written up to nack", t_wr_n - wb, 2);
        t_nack_at = -1;
        tx_fill = tx_idx;
    endtask

    task automatic t_zero;
        int d, lb, tb, wb;
        tb = tx_idx; wb = t_wr_n;
        go(7'h7E, 0, 0, 0);
        wait_end(d, lb);
        chk("R12 address sent", t_addr_byte, 8'hFC);
        chk("R12 no data", t_wr_n - wb, 0);
        chk("R12 nothing taken", tx_idx - tb, 0);
        chk("R12 done", d, 1);
    endtask

    task automatic t_hold_rs;
        int d, lb, sb, st, rb;
        sb = t_stops; st = t_starts;
        load_tx(8'h9C, 8'h00, 8'h00, 8'h00, 1);
        go(7'h44, 0, 1, 1);
        wait_end(d, lb);
        repeat (5) @(negedge clk);
        chk("R8 parked scl low", scl_oe, 1);
        chk("R8 parked sda free", sda_oe, 0);
        chk("R8 no stop", t_stops - sb, 0);
        rb = rx_n;
        t_rdat[0] = 8'h6E; t_rdat[1] = 8'h17; t_rd_len = 2;
        go(7'h44, 1, 2, 0);
        wait_end(d, lb);
        chk("R8 repeated start", t_starts - st, 2);
        chk("R8 rs read byte0", rx_log[rb % 64], 8'h6E);
        chk("R8 rs read byte1", rx_log[(rb + 1) % 64], 8'h17);
        chk("R8 final stop", t_stops - sb, 1);
    endtask

    task automatic t_tx_stall;
        int d, lb, tb, wb;
        tb = tx_idx; wb = t_wr_n;
        tx_en = 0;
        load_tx(8'hB7, 8'h48, 8'h00, 8'h00, 2);
        go(7'h12, 0, 2, 0);
        repeat (200) @(negedge clk);
        chk("R9 stalled scl low a", scl_oe, 1);
        repeat (150) @(negedge clk);
        chk("R9 stalled scl low b", scl_oe, 1);
        chk("R9 busy in stall", busy, 1);
        chk("R9 none taken", tx_idx - tb, 0);
        tx_en = 1;
        wait_end(d, lb);
        chk("R9 byte0 after stall", t_wr[wb % 64], 8'hB7);
        chk("R9 byte1 after stall", t_wr[(wb + 1) % 64], 8'h48);
    endtask

    task automatic t_rx_stall;
        int d, lb, rb;
        rb = rx_n;
        t_rdat[0] = 8'hD2; t_rdat[1] = 8'h2D; t_rd_len = 2;
        rx_ready = 0;
        go(7'h2A, 1, 2, 0);
        repeat (300) @(negedge clk);
        chk("R10 stalled scl low", scl_oe, 1);
        chk("R10 no push", rx_n - rb, 0);
        chk("R10 busy in stall", busy, 1);
        rx_ready = 1;
        wait_end(d, lb);
        chk("R10 byte0", rx_log[rb % 64], 8'hD2);
        chk("R10 byte1", rx_log[(rb + 1) % 64], 8'h2D);
    endtask

    task automatic t_timing;
        int d, lb, hn, ln, hb, lob;
        tim_word0 = {16'd3, 16'd7};
        tim_word1 = '0;
        tim_start_hold = 32'd9;
        exp_hi = 3; exp_lo = 7;
        hn = m_hi_n; ln = m_lo_n; hb = m_hi_bad; lob = m_lo_bad;
        mon_en = 1;
        load_tx(8'h5C, 8'h00, 8'h00, 8'h00, 1);
        go(7'h3B, 0, 1, 0);
        wait_end(d, lb);
        mon_en = 0;
        chk("R2 high runs", m_hi_n - hn, 18);
        chk("R2 low runs", m_lo_n - ln, 19);
        chk("R2 high width errors", m_hi_bad - hb, 0);
        chk("R2 low width errors", m_lo_bad - lob, 0);
        chk("R3 start hold", m_hold_w, 9);
        chk("R2 data intact", t_wr[(t_wr_n - 1) % 64], 8'h5C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_write();
        t_read();
        t_addr_nack();
        t_data_nack();
        t_zero();
        t_hold_rs();
        t_tx_stall();
        t_rx_stall();
        t_timing();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule